// File: doc/BRIEF.md
# Banked program memory address translator

This block sits between a CPU and the external program memories of a cartridge-style system. It turns every CPU address in the range 0x6000-0xFFFF into a paged address for an external program ROM or an external work RAM. It also produces the matching chip enable. A 2-bit layout register decides how the upper 32 KB is cut into windows. Five 8-bit page registers choose which 8 KB page each window shows. Two 2-bit key registers guard writes to RAM.

Software loads the registers through a small write port, which has a strobe, a 3-bit register select and a data byte. The CPU side is purely combinational. The current register contents and the CPU address give the memory address, the enables and the write enable in the same cycle. The thirteen low address bits pass through to both memories unchanged.

Top module: `prg_bank_xlate`

## Requirements
- R1: After reset the layout register holds 3 and page register 4 holds 0xFF; page registers 0-3 and both key registers hold 0.
- R2: While reg_wr is high, the register chosen by reg_sel takes reg_wdata on the next rising clock edge. The encoding is 0 = layout (bits 1:0), 1 = key A (bits 1:0), 2 = key B (bits 1:0), and 3..7 = page registers 0..4. Translation before that edge uses the old value.
- R3: Addresses 0x6000-0x7FFF always reach RAM through page register 0, and bit 7 of that register has no effect.
- R4: The layouts work as follows. Layout 0 is one 32 KB window at 0x8000 served by page 4. Layout 1 has page 2 at 0x8000-0xBFFF and page 4 at 0xC000-0xFFFF. Layout 2 has page 2 at 0x8000-0xBFFF, page 3 at 0xC000-0xDFFF and page 4 at 0xE000-0xFFFF. Layout 3 has pages 1, 2, 3 and 4 on the four 8 KB windows from 0x8000 upward.
- R5: For pages 1-3, bit 7 picks the memory: 0 selects RAM and 1 selects ROM. Page 4 always selects ROM, so 0xE000-0xFFFF is ROM in every layout.
- R6: Page values are 8 KB indices. A 16 KB window replaces page bit 0 with CPU A13. A 32 KB window replaces page bits 1:0 with CPU A14:A13.
- R7: rom_addr[19:13] carries the effective page bits 6:0, and ram_addr[16:13] carries page bits 3:0. Bits 12:0 of both outputs equal cpu_addr[12:0].
- R8: For a RAM access, ram_ce[1] is asserted when effective page bit 2 is 1 and ram_ce[0] is asserted otherwise. At most one of rom_ce, ram_ce[0] and ram_ce[1] is high at a time.
- R9: ram_we is high only for a CPU write (cpu_write = 1) to a RAM window while key A = 2'b10 and key B = 2'b01.
- R10: Addresses below 0x6000 assert no chip enable and no write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| cpu_write | input | 1 | 1 when the CPU access is a write |
| rom_ce | output | 1 | Program ROM enable, active high |
| rom_addr | output | 20 | Program ROM address |
| ram_ce | output | 2 | Work RAM chip enables, active high |
| ram_addr | output | 17 | Work RAM address |
| ram_we | output | 1 | Work RAM write enable, active high |

## Verification
A register write and a CPU access through the window that register controls can occur in the same cycle. The bench provokes this by holding the CPU address on the affected window while it strobes a new page value. It samples the outputs once before the clock edge, where the old mapping is expected. It samples them again after the edge, where the new page and memory type must show. The same reasoning applies to the key registers. A write to a RAM window while a key is being changed must follow the key value that was in place before the edge.

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [15:0] cpu_addr,
  input  logic        cpu_write,
  output logic        rom_ce,
  output logic [19:0] rom_addr,
  output logic [1:0]  ram_ce,
  output logic [16:0] ram_addr,
  output logic        ram_we
);

  logic [1:0] mode, key_a, key_b;
  logic [7:0] page [5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= 2'd3;
      key_a <= 2'd0;
      key_b <= 2'd0;
      for (int i = 0; i < 4; i++) page[i] <= 8'h00;
      page[4] <= 8'hFF;
    end else if (reg_wr) begin
      case (reg_sel)
        3'd0:    mode  <= reg_wdata[1:0];
        3'd1:    key_a <= reg_wdata[1:0];
        3'd2:    key_b <= reg_wdata[1:0];
        default: page[3'(reg_sel - 3'd3)] <= reg_wdata;
      endcase
    end
  end

  logic [2:0] idx;
  logic [1:0] repl;
  logic [7:0] sel;
  logic [6:0] eff;
  logic       mapped, is_ram;

  always_comb begin
    idx  = 3'd0;
    repl = 2'b00;
    if (cpu_addr[15]) begin
      case (mode)
        2'd0: begin idx = 3'd4; repl = 2'b11; end
        2'd1: begin idx = cpu_addr[14] ? 3'd4 : 3'd2; repl = 2'b01; end
        2'd2: begin
          if (!cpu_addr[14]) begin idx = 3'd2; repl = 2'b01; end
          else idx = cpu_addr[13] ? 3'd4 : 3'd3;
        end
        default: idx = 3'd1 + {1'b0, cpu_addr[14:13]};
      endcase
    end
  end

  assign sel    = page[idx];
  assign eff    = {sel[6:2], repl[1] ? cpu_addr[14] : sel[1], repl[0] ? cpu_addr[13] : sel[0]};
  assign mapped = cpu_addr[15] | (cpu_addr[14:13] == 2'b11);
  assign is_ram = mapped & (~cpu_addr[15] | ((idx != 3'd4) & ~sel[7]));

  assign rom_ce   = mapped & ~is_ram;
  assign ram_ce   = {is_ram & eff[2], is_ram & ~eff[2]};
  assign ram_we   = is_ram & cpu_write & (key_a == 2'b10) & (key_b == 2'b01);
  assign rom_addr = {eff, cpu_addr[12:0]};
  assign ram_addr = {eff[3:0], cpu_addr[12:0]};

endmodule

// File: rtl/prg_bank_xlate_chk.sv
module prg_bank_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic [7:0]  reg_wdata,
  input logic [15:0] cpu_addr,
  input logic        cpu_write,
  input logic        rom_ce,
  input logic [1:0]  ram_ce,
  input logic        ram_we,
  input logic [1:0]  mode,
  input logic [1:0]  key_a,
  input logic [1:0]  key_b
);

  AST_LOW_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> (!rom_ce && ram_ce == 2'b00 && !ram_we)); // R10
  AST_SINGLE_CE:  assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_ce, ram_ce})); // R8
  AST_WE_KEYS:    assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_write && ram_ce != 2'b00 && key_a == 2'b10 && key_b == 2'b01)); // R9
  AST_VECTOR_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> rom_ce); // R5
  AST_LOW_RAM:    assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011) |-> (ram_ce != 2'b00 && !rom_ce)); // R3
  AST_MODE_LOAD:  assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd0) |=> (mode == $past(reg_wdata[1:0]))); // R2

endmodule

bind prg_bank_xlate prg_bank_xlate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .cpu_addr(cpu_addr), .cpu_write(cpu_write), .rom_ce(rom_ce), .ram_ce(ram_ce),
  .ram_we(ram_we), .mode(mode), .key_a(key_a), .key_b(key_b)
);

// File: tb/test_prg_bank_xlate.sv
`timescale 1ns/1ps
module test_prg_bank_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [15:0] cpu_addr = 16'd0;
  logic        cpu_write = 1'b0;
  logic        rom_ce;
  logic [19:0] rom_addr;
  logic [1:0]  ram_ce;
  logic [16:0] ram_addr;
  logic        ram_we;

  int errors = 0, checks = 0;
  bit done = 0;
  int sh_mode = 3, sh_ka = 0, sh_kb = 0;
  int sh_pg [5] = '{0, 0, 0, 0, 255};

  always #2.5 clk = ~clk;

  prg_bank_xlate i_prg_bank_xlate (.*);

  task automatic wr_reg(input int s, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 3'(s); reg_wdata = 8'(d);
    @(negedge clk);
    reg_wr = 1'b0;
    if (s == 0) sh_mode = d % 4;
    else if (s == 1) sh_ka = d % 4;
    else if (s == 2) sh_kb = d % 4;
    else sh_pg[s - 3] = d;
  endtask

  task automatic model(input int a, input bit wr, output bit erom, output bit [1:0] eram,
                       output bit ewe, output int pg);
    int r, span, base;
    bit ram;
    erom = 0; eram = 0; ewe = 0; pg = 0;
    if (a < 'h6000) return;
    if (a < 'h8000) begin r = 0; span = 1; base = 'h6000; end
    else case (sh_mode)
      0: begin r = 4; span = 4; base = 'h8000; end
      1: begin r = (a < 'hC000) ? 2 : 4; span = 2; base = (a < 'hC000) ? 'h8000 : 'hC000; end
      2: if (a < 'hC000) begin r = 2; span = 2; base = 'h8000; end
         else begin r = (a < 'hE000) ? 3 : 4; span = 1; base = (a < 'hE000) ? 'hC000 : 'hE000; end
      default: begin r = 1 + (a - 'h8000) / 'h2000; span = 1; base = 'h8000 + (r - 1) * 'h2000; end
    endcase
    ram = (r == 0) ? 1'b1 : (r == 4) ? 1'b0 : (sh_pg[r] < 128);
    pg = ((sh_pg[r] % 128) / span) * span + (a - base) / 'h2000;
    erom = !ram;
    eram = ram ? (((pg / 4) % 2) ? 2'b10 : 2'b01) : 2'b00;
    ewe = ram && wr && sh_ka == 2 && sh_kb == 1;
  endtask

  task automatic check_at(input int a, input bit wr, input string tag);
    bit erom, ewe; bit [1:0] eram; int pg; bit bad;
    cpu_addr = 16'(a); cpu_write = wr;
    #1;
    model(a, wr, erom, eram, ewe, pg);
    bad = (rom_ce !== erom) || (ram_ce !== eram) || (ram_we !== ewe);
    if (erom && rom_addr !== 20'(pg * 'h2000 + a % 'h2000)) bad = 1;
    if (eram != 0 && ram_addr !== 17'((pg % 16) * 'h2000 + a % 'h2000)) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s addr=%h mode=%0d: got ce=%b/%b we=%b rom=%h ram=%h exp ce=%b/%b we=%b page=%h",
               tag, a, sh_mode, rom_ce, ram_ce, ram_we, rom_addr, ram_addr, erom, eram, ewe, pg);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state: layout 3, page 4 = 0xFF, pages 1-3 = RAM page 0
    check_at('hE123, 0, "R1 reset top window");
    check_at('h8456, 0, "R1 reset low window");
    check_at('h6000, 1, "R1 R9 keys locked after reset");

    // R10 low addresses
    for (int a = 0; a < 'h6000; a += 'h0777) check_at(a, 1, "R10 below window");

    // R9 key sweep
    for (int ka = 0; ka < 4; ka++)
      for (int kb = 0; kb < 4; kb++) begin
        wr_reg(1, ka | 'hFC); wr_reg(2, kb);
        check_at('h7ABC, 1, "R9 key combination");
      end

    // R3 R4 R5 R6 R7 R8 sweep: layouts x page patterns x address pages x access type
    wr_reg(1, 2); wr_reg(2, 1);
    for (int pat = 0; pat < 3; pat++) begin
      wr_reg(3, pat == 0 ? 'h8D : pat == 1 ? 'h06 : 'h7B);
      wr_reg(4, pat == 0 ? 'h05 : pat == 1 ? 'hC3 : 'h2E);
      wr_reg(5, pat == 0 ? 'h86 : pat == 1 ? 'h0F : 'hB5);
      wr_reg(6, pat == 0 ? 'h0B : pat == 1 ? 'hA9 : 'h44);
      wr_reg(7, pat == 0 ? 'h37 : pat == 1 ? 'hF2 : 'h69);
      for (int m = 0; m < 4; m++) begin
        wr_reg(0, m | (pat << 4));
        for (int p = 6; p < 16; p++)
          for (int w = 0; w < 2; w++)
            check_at(p * 'h1000 + ((p * 'h137 + pat * 'h51) % 'h1000), w[0], "R3 R4 R5 R6 R7 R8 map");
      end
    end

    // R2 register write coinciding with access through that window
    wr_reg(0, 3); wr_reg(5, 'h84);
    @(negedge clk);
    cpu_addr = 16'hA010; cpu_write = 1'b0;
    reg_wr = 1'b1; reg_sel = 3'd5; reg_wdata = 8'h13;
    #1;
    checks++;
    if (!(rom_ce === 1'b1 && rom_addr[19:13] === 7'h04)) begin
      errors++; $display("FAIL R2 before edge: rom_ce=%b page=%h exp 1/04", rom_ce, rom_addr[19:13]);
    end
    @(negedge clk);
    reg_wr = 1'b0; sh_pg[2] = 'h13;
    #1;
    checks++;
    if (!(ram_ce === 2'b01 && ram_addr[16:13] === 4'h3)) begin
      errors++; $display("FAIL R2 after edge: ram_ce=%b page=%h exp 01/3", ram_ce, ram_addr[16:13]);
    end

    // R2 key change coinciding with RAM write
    @(negedge clk);
    cpu_addr = 16'h6004; cpu_write = 1'b1;
    reg_wr = 1'b1; reg_sel = 3'd2; reg_wdata = 8'h00;
    #1;
    checks++;
    if (ram_we !== 1'b1) begin errors++; $display("FAIL R2 R9 before key edge: we=%b exp 1", ram_we); end
    @(negedge clk);
    reg_wr = 1'b0; sh_kb = 0;
    #1;
    checks++;
    if (ram_we !== 1'b0) begin errors++; $display("FAIL R2 R9 after key edge: we=%b exp 0", ram_we); end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule